// File: doc/BRIEF.md
# Oversampled Edge Tracker and Phase Selector

This block sits at the heart of a clockless serial receiver. The line is sampled at four phase points per bit. Each cycle of the local clock, which runs at half the bit rate, covers two bits. The block receives two sets of raw samples each cycle. The primary set is taken at NPH evenly spaced phases of the clock. The second set comes from a copy of the data that is complemented and delayed by half a phase step. Together the two sets give 2*NPH sample positions per cycle, evenly spaced in time and interleaved. A single register stage captures the samples and keeps the last secondary sample of the previous cycle. An edge term is then computed for every boundary between neighbouring positions inside a bit.

A small tracker keeps the index of the sample position that sits furthest from the data transitions. It moves that index by at most one position per cycle, away from any transition that appears next to it. On each cycle it emits the chosen bits and how many are valid. When the index wraps around the end of a bit, one bit is added or one bit is dropped, and the block raises the matching skip flag. A downstream packer uses the count and the flags to assemble words.

Top module: `oversample_phase_picker`

## Requirements
- R1: A synchronous reset forces the selected position `sel` to 0 and `bits`, `nbits`, `skip_pos` and `skip_neg` to 0.
- R2: A sample set presented at a rising edge shapes `sel`, `bits`, `nbits` and the skip flags that appear after the following rising edge. The input register adds one cycle and the output register adds one more.
- R3: The sample positions within one cycle are ordered p(2k) = `mst_smp[k]` and p(2k+1) = NOT `slv_smp[k]`, for k = 0..NPH-1. The secondary input carries inverted data, so every output bit and every comparison uses its complement as the true level.
- R4: Edge term e[j], for j < NPH-1, is set when p(j) differs from p(j+1) or when p(j+NPH) differs from p(j+NPH+1). Edge term e[NPH-1] is set when p(NPH-1) differs from p(NPH) or when the previous cycle's p(2*NPH-1) differs from p(0).
- R5: When the edge term on the left of the current position, e[(sel-1) mod NPH], is set and e[sel] is clear, `sel` steps to (sel+1) mod NPH.
- R6: When e[sel] is set and e[(sel-1) mod NPH] is clear, `sel` steps to (sel-1) mod NPH.
- R7: When both adjacent edge terms are clear, or both are set, `sel` does not change.
- R8: Without a wrap, `nbits` is 2. `bits[0]` is p(s) and `bits[1]` is p(s+NPH), where s is the new `sel`.
- R9: A step from 0 to NPH-1 raises `skip_pos` and gives `nbits` = 3. The bits are then `bits[0]` = previous p(2*NPH-1), `bits[1]` = p(NPH-1) and `bits[2]` = p(2*NPH-1).
- R10: A step from NPH-1 to 0 raises `skip_neg` and gives `nbits` = 1, with `bits[0]` = p(NPH).
- R11: Bits of `bits` at or above index `nbits` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling-domain clock, half the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mst_smp | input | NPH | Raw samples of the true data copy, one per clock phase |
| slv_smp | input | NPH | Raw samples of the complemented copy, delayed half a phase step |
| sel | output | $clog2(NPH) | Selected sample position within a bit |
| bits | output | 3 | Recovered bits, earliest in bit 0 |
| nbits | output | 2 | Number of valid bits this cycle (1, 2 or 3) |
| skip_pos | output | 1 | An extra bit was produced this cycle |
| skip_neg | output | 1 | A bit was dropped this cycle |

## Verification
The assertions are checked on every cycle. They cover the tracker's stepping rules against the internal edge-term vector: a single step in the correct direction, a hold when both neighbours agree, and a change of at most one position per cycle. They also tie each skip flag to its wrap and its bit count, and require the unused high bits to be zero. The bench's scenarios must show the data path. This includes the inversion of the secondary samples, the use of the previous cycle's last sample, the two-cycle latency, and the exact bit values chosen during skips. Two exhaustive passes over all 256 sample sets cover these, together with a clean stream whose phase drifts one way and then back, which forces wraps in both directions.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int unsigned OSD_DEF_PH = 4;
  localparam int unsigned OSD_BITS_W = 3;
  localparam int unsigned OSD_CNT_W  = 2;

  typedef enum logic [1:0] {
    SKIP_NONE = 2'd0,
    SKIP_POS  = 2'd1,
    SKIP_NEG  = 2'd2
  } skip_e;

  // Valid bit count for a cycle, from its wrap kind (R8, R9, R10)
  function automatic logic [OSD_CNT_W-1:0] skip_count(input skip_e kind);
    case (kind)
      SKIP_POS: return OSD_CNT_W'(3);
      SKIP_NEG: return OSD_CNT_W'(1);
      default:  return OSD_CNT_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/osd_capture.sv
// Input register stage; also holds the last secondary sample of the prior set.
module osd_capture #(
  parameter int unsigned NPH = osd_pkg::OSD_DEF_PH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] i_mst,
  input  logic [NPH-1:0] i_slv,
  output logic [NPH-1:0] o_mst,
  output logic [NPH-1:0] o_slv,
  output logic           o_slv_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_mst      <= '0;
      o_slv      <= '0;
      o_slv_last <= 1'b0;
    end else begin
      o_mst      <= i_mst;
      o_slv      <= i_slv;
      o_slv_last <= o_slv[NPH-1];
    end
  end
endmodule

// File: rtl/osd_edges.sv
// Builds the true-level position vector and the per-boundary edge terms.
// lvl[0] is the previous cycle's last position, lvl[p+1] is position p.
module osd_edges #(
  parameter int unsigned NPH = osd_pkg::OSD_DEF_PH,
  localparam int unsigned NLVL = 2*NPH + 1
) (
  input  logic [NPH-1:0]  i_mst,
  input  logic [NPH-1:0]  i_slv,
  input  logic            i_slv_last,
  output logic [NLVL-1:0] o_lvl,
  output logic [NPH-1:0]  o_edge
);
  // The secondary copy is inverted, so XOR on true levels is XNOR on raw ones (R3)
  assign o_lvl[0] = ~i_slv_last;

  for (genvar k = 0; k < NPH; k++) begin : g_pos
    assign o_lvl[2*k+1] = i_mst[k];
    assign o_lvl[2*k+2] = ~i_slv[k];
  end

  // R4: boundary j lies between positions j and j+1 of each bit
  for (genvar j = 0; j < NPH; j++) begin : g_edge
    if (j < NPH-1) begin : g_inner
      assign o_edge[j] = (o_lvl[j+1] ^ o_lvl[j+2]) |
                         (o_lvl[j+1+NPH] ^ o_lvl[j+2+NPH]);
    end else begin : g_wrap
      assign o_edge[j] = (o_lvl[NPH] ^ o_lvl[NPH+1]) |
                         (o_lvl[0] ^ o_lvl[1]);
    end
  end
endmodule

// File: rtl/osd_tracker.sv
// Position tracker, wrap classification and bit selection.
module osd_tracker
  import osd_pkg::*;
#(
  parameter int unsigned NPH = OSD_DEF_PH,
  localparam int unsigned SEL_W = $clog2(NPH),
  localparam int unsigned NLVL  = 2*NPH + 1,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NLVL-1:0]       i_lvl,
  input  logic [NPH-1:0]        i_edge,
  output logic [SEL_W-1:0]      o_sel,
  output logic [OSD_BITS_W-1:0] o_bits,
  output logic [OSD_CNT_W-1:0]  o_nbits,
  output logic                  o_skip_pos,
  output logic                  o_skip_neg
);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NPH-1);

  function automatic logic [SEL_W-1:0] wrap_inc(input logic [SEL_W-1:0] v);
    return (v == SEL_LAST) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [SEL_W-1:0] wrap_dec(input logic [SEL_W-1:0] v);
    return (v == '0) ? SEL_LAST : v - 1'b1;
  endfunction

  // R5, R6, R7: one step away from a one-sided edge, else hold
  function automatic logic [SEL_W-1:0] step_sel(input logic [SEL_W-1:0] cur,
                                                input logic [NPH-1:0]   e);
    logic on_left, on_right;
    on_left  = e[wrap_dec(cur)];
    on_right = e[cur];
    if (on_left && !on_right) return wrap_inc(cur);
    if (on_right && !on_left) return wrap_dec(cur);
    return cur;
  endfunction

  function automatic skip_e classify(input logic [SEL_W-1:0] cur,
                                     input logic [SEL_W-1:0] nxt);
    if (cur == '0 && nxt == SEL_LAST) return SKIP_POS;
    if (cur == SEL_LAST && nxt == '0) return SKIP_NEG;
    return SKIP_NONE;
  endfunction

  logic [SEL_W-1:0]      sel_q, sel_nxt;
  skip_e                 kind;
  logic [OSD_BITS_W-1:0] bits_nxt;
  logic [LVL_W-1:0]      idx_a, idx_b;

  always_comb begin
    sel_nxt  = step_sel(sel_q, i_edge);
    kind     = classify(sel_q, sel_nxt);
    idx_a    = LVL_W'(sel_nxt) + LVL_W'(1);
    idx_b    = idx_a + LVL_W'(NPH);
    bits_nxt = '0;
    case (kind)
      SKIP_POS: begin
        bits_nxt[0] = i_lvl[0];
        bits_nxt[1] = i_lvl[NPH];
        bits_nxt[2] = i_lvl[2*NPH];
      end
      SKIP_NEG: bits_nxt[0] = i_lvl[NPH+1];
      default: begin
        bits_nxt[0] = i_lvl[idx_a];
        bits_nxt[1] = i_lvl[idx_b];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      o_bits     <= '0;
      o_nbits    <= '0;
      o_skip_pos <= 1'b0;
      o_skip_neg <= 1'b0;
    end else begin
      sel_q      <= sel_nxt;
      o_bits     <= bits_nxt;
      o_nbits    <= skip_count(kind);
      o_skip_pos <= (kind == SKIP_POS);
      o_skip_neg <= (kind == SKIP_NEG);
    end
  end

  assign o_sel = sel_q;
endmodule

// File: rtl/oversample_phase_picker.sv
module oversample_phase_picker
  import osd_pkg::*;
#(
  parameter int unsigned NPH = OSD_DEF_PH,
  localparam int unsigned SEL_W = $clog2(NPH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPH-1:0]        mst_smp,
  input  logic [NPH-1:0]        slv_smp,
  output logic [SEL_W-1:0]      sel,
  output logic [OSD_BITS_W-1:0] bits,
  output logic [OSD_CNT_W-1:0]  nbits,
  output logic                  skip_pos,
  output logic                  skip_neg
);
  localparam int unsigned NLVL = 2*NPH + 1;

  logic [NPH-1:0]  cap_mst, cap_slv;
  logic            cap_slv_last;
  logic [NLVL-1:0] lvl;
  logic [NPH-1:0]  edge_vec;

  osd_capture #(.NPH(NPH)) u_capture (
    .clk(clk), .rst(rst),
    .i_mst(mst_smp), .i_slv(slv_smp),
    .o_mst(cap_mst), .o_slv(cap_slv), .o_slv_last(cap_slv_last)
  );

  osd_edges #(.NPH(NPH)) u_edges (
    .i_mst(cap_mst), .i_slv(cap_slv), .i_slv_last(cap_slv_last),
    .o_lvl(lvl), .o_edge(edge_vec)
  );

  osd_tracker #(.NPH(NPH)) u_tracker (
    .clk(clk), .rst(rst),
    .i_lvl(lvl), .i_edge(edge_vec),
    .o_sel(sel), .o_bits(bits), .o_nbits(nbits),
    .o_skip_pos(skip_pos), .o_skip_neg(skip_neg)
  );
endmodule

// File: rtl/osd_checker.sv
module osd_checker
  import osd_pkg::*;
#(
  parameter int unsigned NPH = OSD_DEF_PH,
  localparam int unsigned SEL_W = $clog2(NPH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [SEL_W-1:0]      sel,
  input logic [OSD_BITS_W-1:0] bits,
  input logic [OSD_CNT_W-1:0]  nbits,
  input logic                  skip_pos,
  input logic                  skip_neg,
  input logic [NPH-1:0]        edge_vec
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NPH-1);

  // Goes high one cycle after reset ends, once outputs carry real results
  logic live = 1'b0;
  always_ff @(posedge clk) live <= !rst;

  function automatic logic [SEL_W-1:0] inc_w(input logic [SEL_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [SEL_W-1:0] dec_w(input logic [SEL_W-1:0] v);
    return (v == '0) ? LAST : v - 1'b1;
  endfunction

  p_step_right_r5: assert property (@(posedge clk) disable iff (rst || !live)
    (edge_vec[dec_w(sel)] && !edge_vec[sel]) |=> (sel == inc_w($past(sel))));

  p_step_left_r6: assert property (@(posedge clk) disable iff (rst || !live)
    (edge_vec[sel] && !edge_vec[dec_w(sel)]) |=> (sel == dec_w($past(sel))));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst || !live)
    (edge_vec[sel] == edge_vec[dec_w(sel)]) |=> $stable(sel));

  p_single_step_r5: assert property (@(posedge clk) disable iff (rst || !live)
    (sel != $past(sel)) |-> (sel == inc_w($past(sel)) || sel == dec_w($past(sel))));

  p_nominal_r8: assert property (@(posedge clk) disable iff (rst || !live)
    (!skip_pos && !skip_neg) |-> (nbits == 2'd2));

  p_pos_skip_r9: assert property (@(posedge clk) disable iff (rst || !live)
    skip_pos |-> (nbits == 2'd3 && sel == LAST && $past(sel) == '0));

  p_neg_skip_r10: assert property (@(posedge clk) disable iff (rst || !live)
    skip_neg |-> (nbits == 2'd1 && sel == '0 && $past(sel) == LAST));

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst || !live)
    (nbits == 2'd1 |-> bits[2:1] == 2'b00) and (nbits == 2'd2 |-> bits[2] == 1'b0));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (sel == '0 && nbits == '0 && bits == '0 && !skip_pos && !skip_neg));
endmodule

bind oversample_phase_picker osd_checker #(.NPH(NPH)) u_osd_checker (
  .clk(clk), .rst(rst), .sel(sel), .bits(bits), .nbits(nbits),
  .skip_pos(skip_pos), .skip_neg(skip_neg), .edge_vec(edge_vec)
);

// File: tb/oversample_phase_picker_bench.sv
`timescale 1ns/1ps
module oversample_phase_picker_bench;
  localparam int NPH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mst = '0, slv = '0;
  logic [1:0] sel;
  logic [2:0] bits;
  logic [1:0] nbits;
  logic       skip_pos, skip_neg;

  int checks = 0, errors = 0;
  int seen_pos = 0, seen_neg = 0;

  // reference state: registered samples, previous last secondary, position
  logic [3:0] mr = '0, sr = '0;
  logic       mprev = 1'b0;
  int         msel = 0;

  always #10 clk = ~clk;

  oversample_phase_picker #(.NPH(NPH)) u_oversample_phase_picker (
    .clk(clk), .rst(rst), .mst_smp(mst), .slv_smp(slv),
    .sel(sel), .bits(bits), .nbits(nbits),
    .skip_pos(skip_pos), .skip_neg(skip_neg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mst = '0; slv = '0;
    repeat (2) @(negedge clk);
    chk("R1 sel after reset", sel, 0);
    chk("R1 bits after reset", bits, 0);
    chk("R1 nbits after reset", nbits, 0);
    chk("R1 skip flags after reset", {skip_pos, skip_neg}, 0);
    rst = 1'b0;
    mr = '0; sr = '0; mprev = 1'b0; msel = 0;
  endtask

  // Drive one sample set; outputs checked at the next falling edge come
  // from the set registered one cycle earlier (R2).
  task automatic do_step(input logic [3:0] nm, input logic [3:0] ns);
    logic       t[0:8];
    logic [3:0] e;
    logic       lft, rgt, ep, en;
    int         nsel, ecnt;
    logic [2:0] ebits;
    mst = nm; slv = ns;
    @(negedge clk);
    t[0] = !mprev;
    for (int k = 0; k < 4; k++) begin
      t[1+2*k] = mr[k];
      t[2+2*k] = !sr[k];
    end
    for (int j = 0; j < 3; j++) e[j] = (t[j+1] != t[j+2]) || (t[j+5] != t[j+6]);
    e[3] = (t[4] != t[5]) || (t[0] != t[1]);
    lft = e[(msel+3)%4];
    rgt = e[msel];
    nsel = msel;
    if (lft && !rgt) nsel = (msel+1)%4;
    else if (rgt && !lft) nsel = (msel+3)%4;
    ep = (msel == 0 && nsel == 3);
    en = (msel == 3 && nsel == 0);
    if (ep) begin ebits = {t[8], t[4], t[0]}; ecnt = 3; end
    else if (en) begin ebits = {2'b00, t[5]}; ecnt = 1; end
    else begin ebits = {1'b0, t[nsel+5], t[nsel+1]}; ecnt = 2; end
    chk("R4 R5 R6 R7 sel", sel, nsel);
    chk("R8 R9 R10 nbits", nbits, ecnt);
    chk("R2 R3 R8 R11 bits", bits, ebits);
    chk("R9 skip_pos", skip_pos, ep);
    chk("R10 skip_neg", skip_neg, en);
    if (skip_pos) seen_pos++;
    if (skip_neg) seen_neg++;
    msel = nsel; mprev = sr[3]; mr = nm; sr = ns;
  endtask

  function automatic logic line_lvl(input int g, input int ph);
    int idx;
    idx = (g + ph) / 4;
    return idx[0] ^ idx[2] ^ idx[3];
  endfunction

  task automatic drift_step(input int c, input int ph);
    logic [3:0] nm, ns;
    for (int k = 0; k < 4; k++) begin
      nm[k] = line_lvl(8*c + 2*k, ph);
      ns[k] = !line_lvl(8*c + 2*k + 1, ph);
    end
    do_step(nm, ns);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // exhaustive pass over all sample sets, then a scrambled order
    for (int v = 0; v < 256; v++) do_step(v[3:0], v[7:4]);
    for (int v = 0; v < 256; v++) begin
      int w;
      w = (v*37 + 11) % 256;
      do_step(w[3:0], w[7:4]);
    end
    // reset in mid-run (R1)
    do_reset();
    // clean stream with phase drifting forward, then back
    for (int c = 0; c < 240; c++) drift_step(c, 1000 + c/6);
    for (int c = 240; c < 480; c++) drift_step(c, 1040 - (c-240)/6);
    chk("R9 positive skips observed", seen_pos > 0, 1);
    chk("R10 negative skips observed", seen_neg > 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule